// File: doc/BRIEF.md
# Peripheral clock control slice

This block holds the clock and reset settings for one peripheral in a single 32-bit control word. A plain synchronous bus writes the word with a write strobe and reads it back at any time. The slice picks one of eight source clock-enable inputs. It passes the picked pulses through a fractional rate divider and then a gate, and drives a one-cycle clock-enable pulse train for the peripheral. Everything runs in the system clock domain. The slice also drives the peripheral's active-low reset from a software-controlled bit.

While the gate is open, a write cannot change the divider, the fractional numerator or the source select. This stops the rate or the parent from changing under a running peripheral. The gate bit and the reset bit stay writable at all times. A write that closes the gate may also load new divider and select values in the same cycle.

A build-time parameter can mark the slice as not fitted. In that case the whole word reads as zero and writes do nothing.

Top module: `pcs_slice`

## Requirements
- R1: After reset the control word reads 0x8000_0000: the slice is present, the gate is closed, source 0 is selected, the ratio is 1/1, `clk_en_out` is 0 and `periph_rst_n` is 0.
- R2: When the slice is fitted, bit 31 reads 1. Bits 29, 27 and 23:4 always read 0 and ignore writes. Writing all ones while the gate is closed reads back 0xD700_000F.
- R3: With PRESENT=0 the word reads 0x0000_0000 whatever is written, and `clk_en_out` and `periph_rst_n` stay 0.
- R4: Bit 30 is the gate. While it reads 0, `clk_en_out` is 0 whatever the source inputs do.
- R5: Bits 26:24 pick the source: `src_en[sel]`. `clk_en_out` can be 1 only in a cycle in which that input is 1, in the same cycle. The other inputs have no effect.
- R6: Bits 2:0 hold the divider D and bit 3 holds the numerator N, both zero-based. On the k-th selected pulse after the gate opens, the slice emits a pulse exactly when floor(k(N+1)/(D+1)) > floor((k-1)(N+1)/(D+1)).
- R7: When N > D, every selected source pulse gives one output pulse, and never more than one.
- R8: A write whose bit 30 is 1, made while the gate already reads 1, leaves bits 26:24 and 3:0 unchanged. Bits 30 and 28 still take the written values.
- R9: A write whose bit 30 is 0 loads bits 26:24 and 3:0 in the same cycle, even if the gate was open before the write.
- R10: `periph_rst_n` follows bit 28: 1 releases the peripheral and 0 holds it in reset. Bit 28 is writable whether the gate is open or closed.
- R11: Each time the gate opens, the divider phase starts from zero. With N=0 and D=2, the first output comes on the third selected pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| src_en | input | 8 | Source clock-enable pulses |
| clk_en_out | output | 1 | Divided, gated clock-enable pulse |
| periph_rst_n | output | 1 | Active-low peripheral reset |

## Verification
Two situations are hard to reach from the ports.

The first is the restart of the divider phase. It only shows after the divider has been left holding a part-filled phase. The stimulus gives a single pulse with a ratio of one in three, closes and reopens the gate, and then counts the pulses until the first output.

The second is the write lock. The bench first opens the gate with one set of fields. It then writes a conflicting set with the gate bit still set, and reads the word back. After that it clears the gate with new fields in the same write.

The ratio itself is swept over every numerator, divider and source index. On each sweep the selected input carries an irregular pulse pattern and the unselected inputs carry its complement.

// File: rtl/pcs_pkg.sv
// Package: layout of the peripheral clock control word.
// Assumes a 32-bit word; field positions are fixed because software decodes them.
package pcs_pkg;
    localparam int WORD_W   = 32;
    localparam int BIT_AVAIL = 31;
    localparam int BIT_RUN   = 30;
    localparam int BIT_RLS   = 28;
    localparam int SEL_LSB   = 24;
    localparam int SEL_W     = 3;
    localparam int NUM_LSB   = 3;
    localparam int NUM_W     = 1;
    localparam int DEN_LSB   = 0;
    localparam int DEN_W     = 3;
    localparam logic [WORD_W-1:0] RESET_WORD = 32'h8000_0000;
endpackage

// File: rtl/pcs_ctl_reg.sv
// Module: control word storage with the write lock.
// Holds gate, reset-release, source select, numerator and divider.
// Assumes single-cycle writes. When PRESENT is 0, every field reads 0 and writes are dropped.
module pcs_ctl_reg #(
    parameter bit PRESENT = 1'b1,
    parameter int SEL_W   = pcs_pkg::SEL_W,
    parameter int NUM_W   = pcs_pkg::NUM_W,
    parameter int DEN_W   = pcs_pkg::DEN_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [pcs_pkg::WORD_W-1:0]  wr_data,
    output logic [pcs_pkg::WORD_W-1:0]  rd_data,
    output logic                        run,
    output logic                        rls,
    output logic [SEL_W-1:0]            sel,
    output logic [NUM_W-1:0]            num,
    output logic [DEN_W-1:0]            den
);
    import pcs_pkg::*;

    generate
        if (PRESENT) begin : g_fitted
            logic             run_q, rls_q;
            logic [SEL_W-1:0] sel_q;
            logic [NUM_W-1:0] num_q;
            logic [DEN_W-1:0] den_q;
            logic             locked;
            logic             unused_bits;

            // A write leaves the rate fields alone when the gate is open and stays open.
            assign locked = run_q && wr_data[BIT_RUN];

            // Store the control fields; the gate and reset bits are always writable.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run_q <= 1'b0;
                    rls_q <= 1'b0;
                    sel_q <= '0;
                    num_q <= '0;
                    den_q <= '0;
                end else if (wr_en) begin
                    run_q <= wr_data[BIT_RUN];
                    rls_q <= wr_data[BIT_RLS];
                    if (!locked) begin
                        sel_q <= wr_data[SEL_LSB +: SEL_W];
                        num_q <= wr_data[NUM_LSB +: NUM_W];
                        den_q <= wr_data[DEN_LSB +: DEN_W];
                    end
                end
            end

            // Build the read-back word; the reserved bits stay zero.
            always_comb begin
                rd_data                       = '0;
                rd_data[BIT_AVAIL]            = 1'b1;
                rd_data[BIT_RUN]              = run_q;
                rd_data[BIT_RLS]              = rls_q;
                rd_data[SEL_LSB +: SEL_W]     = sel_q;
                rd_data[NUM_LSB +: NUM_W]     = num_q;
                rd_data[DEN_LSB +: DEN_W]     = den_q;
            end

            assign run = run_q;
            assign rls = rls_q;
            assign sel = sel_q;
            assign num = num_q;
            assign den = den_q;
            assign unused_bits = ^{wr_data[BIT_AVAIL], wr_data[29], wr_data[27], wr_data[23:4]};
        end else begin : g_absent
            logic unused_bits;

            // The slice is not fitted: constant zero outputs.
            assign rd_data = '0;
            assign run     = 1'b0;
            assign rls     = 1'b0;
            assign sel     = '0;
            assign num     = '0;
            assign den     = '0;
            assign unused_bits = ^{clk, rst_n, wr_en, wr_data};
        end
    endgenerate
endmodule

// File: rtl/pcs_src_mux.sv
// Module: picks one source clock-enable input.
// Assumes the number of sources equals 2**SEL_W, so every select value is a valid index.
module pcs_src_mux #(
    parameter int SEL_W   = pcs_pkg::SEL_W,
    localparam int NUM_SRC = 1 << SEL_W
) (
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [SEL_W-1:0]   sel,
    output logic               hit
);
    // Route the selected source pulse.
    assign hit = src_en[sel];
endmodule

// File: rtl/pcs_frac_div.sv
// Module: zero-based fractional divider built as a phase accumulator.
// Each source pulse adds min(num+1, den+1). Reaching den+1 wraps the phase and emits a pulse.
// Assumes NUM_W <= DEN_W. The phase is held at zero while the gate is closed.
module pcs_frac_div #(
    parameter int NUM_W = pcs_pkg::NUM_W,
    parameter int DEN_W = pcs_pkg::DEN_W,
    localparam int SUM_W = DEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hit,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             pulse,
    output logic [DEN_W-1:0] acc_q
);
    logic [SUM_W-1:0] modulus, step_raw, step, sum, diff;
    logic             wrap;

    // Work out the step, clamped to one wrap per source pulse, and the next phase.
    always_comb begin
        modulus  = {1'b0, den} + SUM_W'(1);
        step_raw = {{(SUM_W-NUM_W){1'b0}}, num} + SUM_W'(1);
        step     = (step_raw > modulus) ? modulus : step_raw;
        sum      = {1'b0, acc_q} + step;
        diff     = sum - modulus;
        wrap     = (sum >= modulus);
    end

    // Emit in the same cycle as the source pulse.
    assign pulse = run && hit && wrap;

    // Advance the phase on each source pulse while gated on.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            acc_q <= '0;
        end else if (hit) begin
            acc_q <= wrap ? diff[DEN_W-1:0] : sum[DEN_W-1:0];
        end
    end
endmodule

// File: rtl/pcs_slice.sv
// Module: top of the peripheral clock control slice.
// Joins the control word, the source mux and the fractional divider.
// Assumes a single clock domain; the output is a clock-enable, not a clock.
module pcs_slice #(
    parameter bit PRESENT = 1'b1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [pcs_pkg::WORD_W-1:0]          wr_data,
    output logic [pcs_pkg::WORD_W-1:0]          rd_data,
    input  logic [(1 << pcs_pkg::SEL_W)-1:0]    src_en,
    output logic                                clk_en_out,
    output logic                                periph_rst_n
);
    import pcs_pkg::*;

    logic             run, rls, hit;
    logic [SEL_W-1:0] sel;
    logic [NUM_W-1:0] num;
    logic [DEN_W-1:0] den;
    logic [DEN_W-1:0] div_acc;

    pcs_ctl_reg #(.PRESENT(PRESENT), .SEL_W(SEL_W), .NUM_W(NUM_W), .DEN_W(DEN_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .run(run), .rls(rls), .sel(sel), .num(num), .den(den)
    );

    pcs_src_mux #(.SEL_W(SEL_W)) u_mux (
        .src_en(src_en), .sel(sel), .hit(hit)
    );

    pcs_frac_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .hit(hit), .num(num), .den(den),
        .pulse(clk_en_out), .acc_q(div_acc)
    );

    // The reset-release bit drives the peripheral reset directly.
    assign periph_rst_n = rls;
endmodule

// File: rtl/pcs_slice_chk.sv
// Module: assertion checker for pcs_slice, attached with bind.
module pcs_slice_chk #(
    parameter bit PRESENT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic [7:0]  src_en,
    input logic        clk_en_out,
    input logic        periph_rst_n,
    input logic [2:0]  acc_q
);
    assert_gate_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[30] |-> !clk_en_out);

    assert_out_needs_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_out |-> src_en[rd_data[26:24]]);

    assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[30] && wr_en && wr_data[30]) |=>
        (rd_data[26:24] == $past(rd_data[26:24]) && rd_data[3:0] == $past(rd_data[3:0])));

    assert_unlock_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (PRESENT && wr_en && !wr_data[30]) |=>
        (rd_data[26:24] == $past(wr_data[26:24]) && rd_data[3:0] == $past(wr_data[3:0])));

    assert_reset_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (periph_rst_n == (PRESENT && $past(wr_data[28]))));

    assert_phase_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[30]) |-> (acc_q == 3'd0));
endmodule

bind pcs_slice pcs_slice_chk #(.PRESENT(PRESENT)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .src_en(src_en), .clk_en_out(clk_en_out), .periph_rst_n(periph_rst_n), .acc_q(div_acc)
);

// File: tb/tb_pcs_slice.sv
module tb_pcs_slice;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [7:0]  src_en = '0;
    logic [31:0] rd_data, rd_abs;
    logic        clk_en_out, out_abs, periph_rst_n, prst_abs;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    pcs_slice #(.PRESENT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .src_en(src_en), .clk_en_out(clk_en_out), .periph_rst_n(periph_rst_n)
    );

    pcs_slice #(.PRESENT(1'b0)) dut_absent (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_abs),
        .src_en(src_en), .clk_en_out(out_abs), .periph_rst_n(prst_abs)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] v);
        @(negedge clk);
        src_en  = '0;
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
        #1;
    endtask

    function automatic logic [31:0] word(input bit g, input bit r, input int s, input int n, input int d);
        return 32'h8000_0000 | (32'(g) << 30) | (32'(r) << 28) | (32'(s) << 24) | (32'(n) << 3) | 32'(d);
    endfunction

    // One cycle of source activity with the selected line at 'on' and the rest at its complement.
    task automatic pulse_cycle(input int s, input bit on, input bit exp_out, input string req);
        @(negedge clk);
        src_en    = on ? 8'h00 : 8'hFF;
        src_en[s] = on;
        #1;
        check(req, {31'b0, clk_en_out}, {31'b0, exp_out});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state, with the sources active
        src_en = 8'hFF;
        #0.5;
        check("R1 word", rd_data, 32'h8000_0000);
        check("R1 out", {31'b0, clk_en_out}, 32'd0);
        check("R1 prst", {31'b0, periph_rst_n}, 32'd0);

        // R2: reserved bits read zero; write all ones with the gate closed
        write_word(32'hFFFF_FFFF);
        check("R2 mask", rd_data, 32'hD700_000F);
        check("R10 release", {31'b0, periph_rst_n}, 32'd1);
        // R3: the absent slice ignores everything
        check("R3 word", rd_abs, 32'd0);
        check("R3 prst", {31'b0, prst_abs}, 32'd0);
        // R9: clearing the gate loads fields even though the gate was open
        write_word(32'h0000_0000);
        check("R9 clear", rd_data, 32'h8000_0000);

        // R4: gate closed blocks every pulse
        write_word(word(0, 1, 0, 1, 0));
        for (int c = 0; c < 6; c++) begin
            pulse_cycle(0, 1'b1, 1'b0, "R4 gated");
            check("R3 out", {31'b0, out_abs}, 32'd0);
        end

        // R8: locked fields while the gate stays open; R10: reset bit still writes
        write_word(word(1, 1, 2, 0, 5));
        write_word(word(1, 0, 7, 1, 1));
        check("R8 lock", rd_data, 32'hC200_0005);
        check("R10 locked write", {31'b0, periph_rst_n}, 32'd0);
        write_word(word(0, 1, 7, 1, 1));
        check("R9 load", rd_data, 32'h9700_0009);

        // R11: phase restarts when the gate reopens
        write_word(word(0, 1, 0, 0, 2));
        write_word(word(1, 1, 0, 0, 2));
        pulse_cycle(0, 1'b1, 1'b0, "R11 pre");
        write_word(word(0, 1, 0, 0, 2));
        write_word(word(1, 1, 0, 0, 2));
        pulse_cycle(0, 1'b1, 1'b0, "R11 first");
        pulse_cycle(0, 1'b1, 1'b0, "R11 second");
        pulse_cycle(0, 1'b1, 1'b1, "R11 third");

        // R5/R6/R7: sweep every numerator, divider and source
        for (int n = 0; n < 2; n++) begin
            for (int d = 0; d < 8; d++) begin
                for (int s = 0; s < 8; s++) begin
                    int step, mdl, k;
                    step = (n + 1 < d + 1) ? n + 1 : d + 1;
                    mdl  = d + 1;
                    k    = 0;
                    write_word(word(0, 1, s, n, d));
                    write_word(word(1, 1, s, n, d));
                    check("R6 cfg", rd_data, word(1, 1, s, n, d));
                    for (int c = 0; c < 20; c++) begin
                        bit on, exp_o;
                        on = ((c % 3) != 1) ^ ((c % 7) == 5);
                        exp_o = 1'b0;
                        if (on) begin
                            k++;
                            exp_o = ((k * step) / mdl) > (((k - 1) * step) / mdl);
                        end
                        if (n > d)
                            pulse_cycle(s, on, on, "R7 every pulse");
                        else if (!on)
                            pulse_cycle(s, on, 1'b0, "R5 unselected");
                        else
                            pulse_cycle(s, on, exp_o, "R6 ratio");
                    end
                end
            end
        end

        // R3: the absent slice still reads zero after all traffic
        check("R3 final", rd_abs, 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule